// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits in front of a PCI Express root port. It turns one configuration request, given as bus, device, function and register offset with a read/write flag, into the local address the processor side must use. It also produces the outbound translation-window settings that go with that address. Requests on bus 0 are aimed at the root port's own register space. Requests on any other bus are sent through a shared outbound window, which must be reprogrammed with the routing ID of the target function.

Each bus has a fixed limit on which device numbers are legal. A request to a device beyond that limit is blocked: nothing is reprogrammed, and a blocked read is answered with all ones, as if no function were present. The translation is registered. Every accepted request gives exactly one response cycle, one clock later, and back-to-back requests give back-to-back responses.

The control is a two-state machine. `ST_IDLE` means no response is being presented. `ST_RESP` means the registered response is on the outputs. The transitions are as follows:
- IDLE→RESP (accept): a request arrives.
- RESP→RESP (stream): another request arrives while a response is shown.
- RESP→IDLE (drain): no request arrives.
- IDLE→IDLE (wait): no request arrives.

Top module: `cfg_xlate`

## Requirements
- R1: After reset and with no request, `rsp_valid` is 0.
- R2: A request sampled on a rising edge gives `rsp_valid`=1 for exactly the following cycle. Requests on consecutive cycles give consecutive response cycles. `rsp_valid` is never 1 without a request in the cycle before.
- R3: The legal devices are limited by bus. On bus 0, only devices 0 and 1 are legal. On bus 1, only device 0 is legal. On bus 2 and above, every device is legal. An illegal request is reported with `rsp_blocked`=1.
- R4: A blocked read (`req_write`=0) returns `rsp_rdata`=32'hFFFFFFFF. Every other response returns `rsp_rdata`=0.
- R5: For a legal request, `rsp_type` is 3'd4 (type 0 configuration) on buses 0 and 1, and 3'd5 (type 1 configuration) on bus 2 and above. A blocked response gives `rsp_type`=0.
- R6: A legal bus 0 request gives `rsp_addr` = 32'h01FFC000 + aligned offset, with `rsp_tgt_we`=0.
- R7: A legal request on a bus other than 0 gives `rsp_addr` = 32'h01F00000 + aligned offset, with `rsp_tgt_we`=1. In `rsp_tgt`, the bus sits in bits 31:24, the device in bits 23:19 and the function in bits 18:16, and bits 15:0 are 0.
- R8: The aligned offset is the register offset with bits 1:0 cleared, so `rsp_addr[1:0]` is always 0.
- R9: A blocked response gives `rsp_addr`=0, `rsp_tgt_we`=0 and `rsp_tgt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | 12 | Register byte offset |
| rsp_valid | output | 1 | Response valid, one cycle per request |
| rsp_blocked | output | 1 | Request targeted an illegal device |
| rsp_addr | output | 32 | Local address for the access |
| rsp_type | output | 3 | Window type (4 = type 0, 5 = type 1) |
| rsp_tgt_we | output | 1 | Reprogram the window target |
| rsp_tgt | output | 32 | Window target value |
| rsp_rdata | output | 32 | Fill data for blocked reads |

## Verification
The bench looks for off-by-one device limits, such as device 1 on bus 1 or device 2 on bus 0. A design with a wrong limit would either block a legal function or let an access reach a slot that does not exist. It checks that bus 1 still uses a type 0 window while bus 2 switches to type 1. A wrong threshold there would send requests with the wrong configuration type. It uses offsets with nonzero low bits and the maximum offset, which would expose a misaligned address or an overflow into the base. Finally, it sends back-to-back requests and single requests. These would show a response pulse that is lost or stretched, and a bus 0 access or a blocked access that wrongly reprograms the window target.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } cfgx_state_e;

    localparam int TYPE_W = 3;
    localparam logic [TYPE_W-1:0] WTYPE_NONE = 3'd0;
    localparam logic [TYPE_W-1:0] WTYPE_CFG0 = 3'd4;
    localparam logic [TYPE_W-1:0] WTYPE_CFG1 = 3'd5;

endpackage

// File: rtl/cfgx_legal.sv
module cfgx_legal #(
    parameter int BUS_W       = 8,
    parameter int DEV_W       = 5,
    parameter int ROOT_DEVS   = 2,
    parameter int LINK_DEVS   = 1
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [DEV_W-1:0] dev_i,
    output logic             legal_o
);
    localparam int CNT_W = DEV_W + 1;

    logic [CNT_W-1:0] dev_ext;
    assign dev_ext = CNT_W'(dev_i);

    always_comb begin
        if (bus_i == '0) begin
            legal_o = (dev_ext < CNT_W'(ROOT_DEVS));
        end else if (bus_i == BUS_W'(1)) begin
            legal_o = (dev_ext < CNT_W'(LINK_DEVS));
        end else begin
            legal_o = 1'b1;
        end
    end

    // R3: any device on a bus numbered 2 or above is legal
    always_comb begin
        if (bus_i > BUS_W'(1)) begin
            assert_far_bus_open_R3: assert (legal_o);
        end
    end

endmodule

// File: rtl/cfgx_map.sv
module cfgx_map
    import cfgx_pkg::*;
#(
    parameter int               BUS_W      = 8,
    parameter int               DEV_W      = 5,
    parameter int               FN_W       = 3,
    parameter int               REG_W      = 12,
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h01F0_0000
) (
    input  logic [BUS_W-1:0]  bus_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic              legal_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              tgt_we_o,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int RID_W   = BUS_W + DEV_W + FN_W;
    localparam int PAD_W   = ADDR_W - RID_W;

    logic [REG_W-1:0]  reg_aligned;
    logic [ADDR_W-1:0] offset;
    logic              local_bus;
    logic              type1_bus;
    logic [RID_W-1:0]  rid;

    assign reg_aligned = {reg_i[REG_W-1:2], 2'b00};
    assign offset      = ADDR_W'(reg_aligned);
    assign local_bus   = (bus_i == '0);
    assign type1_bus   = (bus_i > BUS_W'(1));
    assign rid         = {bus_i, dev_i, fn_i};

    always_comb begin
        addr_o   = '0;
        type_o   = WTYPE_NONE;
        tgt_we_o = 1'b0;
        tgt_o    = '0;
        if (legal_i) begin
            type_o = type1_bus ? WTYPE_CFG1 : WTYPE_CFG0;
            if (local_bus) begin
                addr_o = LOCAL_BASE + offset;
            end else begin
                addr_o   = WIN_BASE + offset;
                tgt_we_o = 1'b1;
                tgt_o    = {rid, {PAD_W{1'b0}}};
            end
        end
    end

    // R8: the alignment step never leaves low address bits set
    always_comb begin
        assert_offset_aligned_R8: assert (offset[1:0] == 2'b00);
    end

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfgx_pkg::*;
#(
    parameter int                BUS_W      = 8,
    parameter int                DEV_W      = 5,
    parameter int                FN_W       = 3,
    parameter int                REG_W      = 12,
    parameter int                ADDR_W     = 32,
    parameter int                ROOT_DEVS  = 2,
    parameter int                LINK_DEVS  = 1,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] IO_BASE    = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] SPAN       = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_func,
    input  logic [REG_W-1:0]  req_reg,
    output logic              rsp_valid,
    output logic              rsp_blocked,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_type,
    output logic              rsp_tgt_we,
    output logic [ADDR_W-1:0] rsp_tgt,
    output logic [ADDR_W-1:0] rsp_rdata
);
    localparam logic [ADDR_W-1:0] WIN_BASE = IO_BASE + SPAN - WIN_SIZE;

    cfgx_state_e       state_q, state_d;

    logic              legal;
    logic [ADDR_W-1:0] map_addr;
    logic [TYPE_W-1:0] map_type;
    logic              map_tgt_we;
    logic [ADDR_W-1:0] map_tgt;

    cfgx_legal #(
        .BUS_W     (BUS_W),
        .DEV_W     (DEV_W),
        .ROOT_DEVS (ROOT_DEVS),
        .LINK_DEVS (LINK_DEVS)
    ) u_legal (
        .bus_i   (req_bus),
        .dev_i   (req_dev),
        .legal_o (legal)
    );

    cfgx_map #(
        .BUS_W      (BUS_W),
        .DEV_W      (DEV_W),
        .FN_W       (FN_W),
        .REG_W      (REG_W),
        .ADDR_W     (ADDR_W),
        .LOCAL_BASE (LOCAL_BASE),
        .WIN_BASE   (WIN_BASE)
    ) u_map (
        .bus_i    (req_bus),
        .dev_i    (req_dev),
        .fn_i     (req_func),
        .reg_i    (req_reg),
        .legal_i  (legal),
        .addr_o   (map_addr),
        .type_o   (map_type),
        .tgt_we_o (map_tgt_we),
        .tgt_o    (map_tgt)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;  // accept / wait
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;  // stream / drain
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // response registers, loaded on each accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_blocked <= 1'b0;
            rsp_addr    <= '0;
            rsp_type    <= WTYPE_NONE;
            rsp_tgt_we  <= 1'b0;
            rsp_tgt     <= '0;
            rsp_rdata   <= '0;
        end else if (req_valid) begin
            rsp_blocked <= !legal;
            rsp_addr    <= map_addr;
            rsp_type    <= map_type;
            rsp_tgt_we  <= map_tgt_we;
            rsp_tgt     <= map_tgt;
            rsp_rdata   <= (!legal && !req_write) ? '1 : '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R2: a response only follows a request
    assert_pulse_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R2: every request yields a response cycle
    assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: a device on bus 0 above 1, or on bus 1 above 0, is blocked
    assert_limit_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_bus == '0 && req_dev > DEV_W'(1)) ||
                       (req_bus == BUS_W'(1) && req_dev != '0)))
        |=> rsp_blocked);

    // R4: a blocked read is answered with all ones
    assert_blocked_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_blocked && !$past(req_write)) |-> (rsp_rdata == '1));

    // R5: window type follows the bus threshold
    assert_window_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_blocked) |->
        (rsp_type == (($past(req_bus) > BUS_W'(1)) ? 3'd5 : 3'd4)));

    // R6: local bus accesses leave the window target alone
    assert_local_no_tgt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_bus) == '0) |-> !rsp_tgt_we);

    // R8: every response address is dword aligned
    assert_addr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr[1:0] == 2'b00));

    // R9: blocked requests program nothing
    assert_blocked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_blocked) |-> (!rsp_tgt_we && rsp_addr == '0));

endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_reg = '0;
    logic        rsp_valid, rsp_blocked, rsp_tgt_we;
    logic [31:0] rsp_addr, rsp_tgt, rsp_rdata;
    logic [2:0]  rsp_type;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked), .rsp_addr(rsp_addr),
        .rsp_type(rsp_type), .rsp_tgt_we(rsp_tgt_we), .rsp_tgt(rsp_tgt),
        .rsp_rdata(rsp_rdata)
    );

    // row: {write, bus, dev, func, reg, exp_blocked, exp_type, exp_tgt_we, exp_addr}
    localparam int NV = 10;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 8'd0,   5'd0,  3'd0, 12'h010, 1'b0, 3'd4, 1'b0, 32'h01FFC010}, // R6
        {1'b0, 8'd0,   5'd1,  3'd2, 12'h0FF, 1'b0, 3'd4, 1'b0, 32'h01FFC0FC}, // R6 R8
        {1'b0, 8'd0,   5'd2,  3'd0, 12'h000, 1'b1, 3'd0, 1'b0, 32'h00000000}, // R3
        {1'b1, 8'd1,   5'd0,  3'd5, 12'h103, 1'b0, 3'd4, 1'b1, 32'h01F00100}, // R5 R7
        {1'b0, 8'd1,   5'd1,  3'd0, 12'h040, 1'b1, 3'd0, 1'b0, 32'h00000000}, // R3 R4
        {1'b1, 8'd1,   5'd31, 3'd1, 12'h040, 1'b1, 3'd0, 1'b0, 32'h00000000}, // R4 R9
        {1'b0, 8'd2,   5'd31, 3'd7, 12'hFFF, 1'b0, 3'd5, 1'b1, 32'h01F00FFC}, // R5 R8
        {1'b1, 8'd255, 5'd17, 3'd3, 12'h802, 1'b0, 3'd5, 1'b1, 32'h01F00800}, // R7
        {1'b0, 8'd0,   5'd31, 3'd0, 12'h003, 1'b1, 3'd0, 1'b0, 32'h00000000}, // R3 R9
        {1'b1, 8'd0,   5'd1,  3'd0, 12'h007, 1'b0, 3'd4, 1'b0, 32'h01FFC004}  // R6 R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [65:0] v);
        req_valid = 1'b1;
        req_write = v[65];
        req_bus   = v[64:57];
        req_dev   = v[56:52];
        req_func  = v[51:49];
        req_reg   = v[48:37];
    endtask

    task automatic check_row(input logic [65:0] v);
        logic [31:0] exp_tgt;
        logic [31:0] exp_rd;
        exp_tgt = v[32] ? {v[64:57], v[56:52], v[51:49], 16'h0} : 32'h0;
        exp_rd  = (v[36] && !v[65]) ? 32'hFFFFFFFF : 32'h0;
        check("R2 valid",        {31'b0, rsp_valid},   32'd1);
        check("R3 blocked",      {31'b0, rsp_blocked}, {31'b0, v[36]});
        check("R5 type",         {29'b0, rsp_type},    {29'b0, v[35:33]});
        check("R6/R7/R9 tgt_we", {31'b0, rsp_tgt_we},  {31'b0, v[32]});
        check("R6/R7/R8 addr",   rsp_addr,             v[31:0]);
        check("R7/R9 tgt",       rsp_tgt,              exp_tgt);
        check("R4 rdata",        rsp_rdata,            exp_rd);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid idle", {31'b0, rsp_valid}, 32'd0);

        // table walk: single requests separated by an idle cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(posedge clk);
            #1;
            req_valid = 1'b0;
            check_row(VEC[i]);
            @(posedge clk);
            #1;
            check("R2 pulse one cycle", {31'b0, rsp_valid}, 32'd0);
        end

        // R2: back-to-back requests give back-to-back pulses with fresh data
        @(negedge clk);
        drive(VEC[6]);
        @(posedge clk);
        #1;
        drive(VEC[2]);
        check_row(VEC[6]);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check_row(VEC[2]);
        @(posedge clk);
        #1;
        check("R2 drain", {31'b0, rsp_valid}, 32'd0);

        // R2: idle inputs changing without req_valid produce no response
        @(negedge clk);
        req_bus = 8'd3;
        req_dev = 5'd4;
        @(posedge clk);
        #1;
        check("R2 no request", {31'b0, rsp_valid}, 32'd0);

        // R1: reset in the middle clears the response
        @(negedge clk);
        drive(VEC[3]);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 async reset valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 async reset tgt_we", {31'b0, rsp_tgt_we}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule